// File: doc/BRIEF.md
# Receive Character Queue with Error-Mode Status

This block sits between a serial receiver and a host and buffers completed characters. A small queue of holding registers (three by default) keeps each character together with its parity-error, framing-error and break bits. Behind the queue there is one staging slot. A character that arrives while the queue is full waits there, so four characters can be pending in total. The host reads the head character through a data port, and that read pops the entry. Status outputs are always visible and reading them changes nothing.

Two error-reporting modes are available. In per-character mode, the error outputs show the flags of the entry now at the head. In accumulate mode, the error outputs are a sticky OR of the flags of every entry that has become the head since the last clear-errors command. Overrun is kept apart from the stored entries as its own sticky flag. One interrupt output follows either the "data available" flag or the "queue full" flag, as the host selects.

Top module: `rx_char_fifo`

## Requirements
- R1: After a synchronous reset the block holds no character. `st_ready`, `st_full`, all error flags, `st_ovr` and `irq` are 0, and `rd_data` reads 0.
- R2: Characters leave the block in arrival order. `rd_data` always shows the head character, and a cycle with `rd_en` high while a character is present removes that head.
- R3: `st_ready` is 1 whenever the queue holds at least one character. `st_full` is 1 exactly when all DEPTH queue positions are occupied.
- R4: A character that arrives while the queue is full is held in the staging slot. When the head is popped, the staged character enters the queue in the same cycle, so `st_full` stays 1. If a pop and a new character happen in the same cycle while the slot is occupied, the new character takes the slot and no overrun is flagged.
- R5: A character that arrives while the queue is full, the staging slot is occupied and no pop happens sets the sticky `st_ovr` and replaces the staged character. `st_ovr` is cleared only by `clr_err`. If an overrun occurs in the same cycle as `clr_err`, the overrun wins.
- R6: Each entry keeps its own parity, framing and break bits. With `blk_mode`=0, `st_pe`, `st_fe` and `st_brk` equal the bits of the current head entry, and they are 0 when the queue is empty.
- R7: With `blk_mode`=1, `st_pe`, `st_fe` and `st_brk` are the OR of the bits of every entry that has reached the head since the last `clr_err`.
- R8: `clr_err` clears the accumulated flags and `st_ovr` and leaves the queue contents unchanged. If an entry reaches the head in the same cycle, its bits are accumulated after the clear.
- R9: `irq` equals `st_full` when `irq_sel_full`=1 and equals `st_ready` otherwise.
- R10: A `rd_en` while the queue is empty has no effect. The queue stays empty, and later characters come out intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle strobe: the receiver has completed a character |
| wr_data | input | DATA_W | Completed character |
| wr_pe | input | 1 | Parity error of the completed character |
| wr_fe | input | 1 | Framing error of the completed character |
| wr_brk | input | 1 | Break indication of the completed character |
| rd_en | input | 1 | Data-port read; pops the head entry |
| clr_err | input | 1 | Clear-errors command |
| blk_mode | input | 1 | 1 = accumulate error mode, 0 = per-character mode |
| irq_sel_full | input | 1 | Interrupt source: 1 = full flag, 0 = ready flag |
| rd_data | output | DATA_W | Head character (0 when empty) |
| st_ready | output | 1 | At least one character queued |
| st_full | output | 1 | All queue positions occupied |
| st_pe | output | 1 | Reported parity error |
| st_fe | output | 1 | Reported framing error |
| st_brk | output | 1 | Reported break |
| st_ovr | output | 1 | Sticky overrun |
| irq | output | 1 | Selected interrupt |

## Verification
The bench builds the block with its default DEPTH=3 and DATA_W=8, so every fill level can be reached with a handful of writes. The sweep runs from an empty queue up to two characters past the overrun point, which covers the staging slot and slot replacement in every run. With three entries, every combination of the three-bit error pattern across three successive heads (512 cases) is replayed in accumulate mode and compared against a bitwise OR computed in the bench. Cases where a pop coincides with a write, or a clear coincides with a new head, are driven on purpose.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Error bits that travel with each stored character
  typedef struct packed {
    logic pe;
    logic fe;
    logic brk;
  } rxq_flags_t;

  localparam int FLAG_W = 3;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  rxq_flags_t        wr_flags,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head_data,
  output rxq_flags_t        head_flags,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic              new_head,
  output rxq_flags_t        new_head_flags,
  output logic              ovr_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int ENT_W = DATA_W + FLAG_W;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_ptr_inc, wr_ptr_inc;
  logic [ENT_W-1:0] stg_q;
  logic             stg_vld;
  logic [ENT_W-1:0] in_ent, push_ent, head_ent, next_ent;
  logic             pop, stg_move, room_after, push, stg_load;
  logic [CNT_W-1:0] count_nxt;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign in_ent     = {wr_data, wr_flags};
  assign rd_ptr_inc = ptr_inc(rd_ptr);
  assign wr_ptr_inc = ptr_inc(wr_ptr);

  assign pop        = rd_en && (count != '0);
  assign stg_move   = pop && stg_vld;
  assign room_after = (count != CNT_FULL) || pop;
  assign push       = stg_move || (wr_valid && !stg_vld && room_after);
  assign push_ent   = stg_move ? stg_q : in_ent;
  assign stg_load   = wr_valid && (stg_vld || !room_after);
  assign ovr_evt    = wr_valid && stg_vld && !pop;
  assign count_nxt  = count + CNT_W'(push) - CNT_W'(pop);

  // Head changes when a pop exposes a second entry or a push fills an empty head
  assign new_head = (pop && count_nxt != '0) || (count == '0 && push);
  assign next_ent = (pop && count > CNT_ONE) ? mem[rd_ptr_inc] : push_ent;
  assign new_head_flags = rxq_flags_t'(next_ent[FLAG_W-1:0]);

  // Storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      stg_vld <= 1'b0;
      stg_q   <= '0;
    end else begin
      if (pop)  rd_ptr <= rd_ptr_inc;
      if (push) wr_ptr <= wr_ptr_inc;
      count <= count_nxt;
      if (stg_load) begin
        stg_q   <= in_ent;
        stg_vld <= 1'b1;
      end else if (stg_move) begin
        stg_vld <= 1'b0;
      end
    end
  end

  assign head_ent   = (count != '0) ? mem[rd_ptr] : '0;
  assign head_data  = head_ent[ENT_W-1:FLAG_W];
  assign head_flags = rxq_flags_t'(head_ent[FLAG_W-1:0]);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       blk_mode,
  input  logic       irq_sel_full,
  input  logic       clr_err,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  rxq_flags_t head_flags,
  input  logic       new_head,
  input  rxq_flags_t new_head_flags,
  input  logic       ovr_evt,
  output logic       st_ready,
  output logic       st_full,
  output rxq_flags_t st_flags,
  output logic       st_ovr,
  output logic       irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  rxq_flags_t acc_q;
  logic       ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      // Clear first, then fold in an entry reaching the head this cycle
      acc_q <= (clr_err ? rxq_flags_t'('0) : acc_q) |
               (new_head ? new_head_flags : rxq_flags_t'('0));
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (clr_err) ovr_q <= 1'b0;
    end
  end

  assign st_ready = (count != '0);
  assign st_full  = (count == CNT_W'(DEPTH));
  assign st_flags = blk_mode ? acc_q : head_flags;
  assign st_ovr   = ovr_q;
  assign irq      = irq_sel_full ? st_full : st_ready;
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pe,
  input  logic              wr_fe,
  input  logic              wr_brk,
  input  logic              rd_en,
  input  logic              clr_err,
  input  logic              blk_mode,
  input  logic              irq_sel_full,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_ready,
  output logic              st_full,
  output logic              st_pe,
  output logic              st_fe,
  output logic              st_brk,
  output logic              st_ovr,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  rxq_flags_t       in_flags, head_flags, nh_flags, rep_flags;
  logic [CNT_W-1:0] count;
  logic             new_head, ovr_evt;

  assign in_flags = '{pe: wr_pe, fe: wr_fe, brk: wr_brk};

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_flags(in_flags), .rd_en(rd_en), .head_data(rd_data),
    .head_flags(head_flags), .count(count), .new_head(new_head),
    .new_head_flags(nh_flags), .ovr_evt(ovr_evt)
  );

  rxq_status #(.DEPTH(DEPTH)) status_i (
    .clk(clk), .rst(rst), .blk_mode(blk_mode), .irq_sel_full(irq_sel_full),
    .clr_err(clr_err), .count(count), .head_flags(head_flags),
    .new_head(new_head), .new_head_flags(nh_flags), .ovr_evt(ovr_evt),
    .st_ready(st_ready), .st_full(st_full), .st_flags(rep_flags),
    .st_ovr(st_ovr), .irq(irq)
  );

  assign st_pe  = rep_flags.pe;
  assign st_fe  = rep_flags.fe;
  assign st_brk = rep_flags.brk;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              rd_en,
  input logic              clr_err,
  input logic              blk_mode,
  input logic [DATA_W-1:0] rd_data,
  input logic              st_ready,
  input logic              st_full,
  input logic              st_pe,
  input logic              st_fe,
  input logic              st_brk,
  input logic              st_ovr,
  input logic              irq
);
  // R3
  full_implies_ready_chk: assert property (@(posedge clk) disable iff (rst)
    st_full |-> st_ready);

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st_ovr && !clr_err) |=> st_ovr);

  // R8
  ovr_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !wr_valid) |=> !st_ovr);

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid && !rd_en) |=> ($stable(rd_data) && $stable(st_ready) && $stable(st_full)));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!st_ready && rd_en && !wr_valid) |=> !st_ready);

  // R9
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    !st_ready |-> !irq);

  // R6
  char_mode_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!blk_mode && !st_ready) |-> !(st_pe || st_fe || st_brk));
endmodule

bind rx_char_fifo rxq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_en(rd_en),
  .clr_err(clr_err), .blk_mode(blk_mode), .rd_data(rd_data),
  .st_ready(st_ready), .st_full(st_full), .st_pe(st_pe), .st_fe(st_fe),
  .st_brk(st_brk), .st_ovr(st_ovr), .irq(irq)
);

// File: tb/rx_char_fifo_tb_top.sv
module rx_char_fifo_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 0, wr_pe = 0, wr_fe = 0, wr_brk = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_en = 0, clr_err = 0, blk_mode = 0, irq_sel_full = 0;
  logic [DATA_W-1:0] rd_data;
  logic st_ready, st_full, st_pe, st_fe, st_brk, st_ovr, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_pe(wr_pe), .wr_fe(wr_fe), .wr_brk(wr_brk), .rd_en(rd_en),
    .clr_err(clr_err), .blk_mode(blk_mode), .irq_sel_full(irq_sel_full),
    .rd_data(rd_data), .st_ready(st_ready), .st_full(st_full),
    .st_pe(st_pe), .st_fe(st_fe), .st_brk(st_brk), .st_ovr(st_ovr), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int flg();
    return {29'd0, st_pe, st_fe, st_brk};
  endfunction

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  // One cycle of stimulus; inputs return to idle at the next falling edge
  task automatic cyc(input bit w, input logic [7:0] d, input logic [2:0] f,
                     input bit r, input bit c);
    wr_valid = w; wr_data = d; {wr_pe, wr_fe, wr_brk} = f;
    rd_en = r; clr_err = c;
    @(negedge clk);
    wr_valid = 0; rd_en = 0; clr_err = 0;
  endtask

  function automatic logic [7:0] dval(input int i);
    return 8'h40 + 8'(i);
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    chk("R1 ready", st_ready, 0);
    chk("R1 full", st_full, 0);
    chk("R1 flags", flg(), 0);
    chk("R1 ovr", st_ovr, 0);
    chk("R1 irq", irq, 0);
    chk("R1 data", rd_data, 0);

    // Fill sweep: 0..6 characters, then drain (R2..R6, R9)
    for (int n = 0; n <= 6; n++) begin
      int nout;
      int idx;
      do_reset();
      blk_mode = 0;
      for (int i = 0; i < n; i++) cyc(1, dval(i), 3'(i), 0, 0);
      chk("R3 ready", st_ready, (n >= 1));
      chk("R3 full", st_full, (n >= DEPTH));
      chk("R5 ovr", st_ovr, (n > DEPTH + 1));
      irq_sel_full = 0; #1;
      chk("R9 irq ready", irq, (n >= 1));
      irq_sel_full = 1; #1;
      chk("R9 irq full", irq, (n >= DEPTH));
      irq_sel_full = 0;
      nout = (n > DEPTH + 1) ? DEPTH + 1 : n;
      for (int k = 0; k < nout; k++) begin
        idx = (n > DEPTH + 1 && k == DEPTH) ? n - 1 : k;
        chk("R2 data order", rd_data, dval(idx));
        chk("R6 head flags", flg(), idx % 8);
        cyc(0, 0, 0, 1, 0);
        if (n >= DEPTH + 1 && k == 0) chk("R4 stage refills", st_full, 1);
      end
      chk("R2 drained", st_ready, 0);
      chk("R5 ovr kept", st_ovr, (n > DEPTH + 1));
      // R10: read on empty, then a character must come out intact
      cyc(0, 0, 0, 1, 0);
      chk("R10 empty read", st_ready, 0);
      cyc(1, 8'hA5, 3'b101, 0, 0);
      chk("R10 data after", rd_data, 8'hA5);
      chk("R10 flags after", flg(), 5);
      // R8: clear drops overrun, keeps content
      cyc(0, 0, 0, 0, 1);
      chk("R8 ovr cleared", st_ovr, 0);
      chk("R8 content kept", rd_data, 8'hA5);
    end

    // R4: pop and write together while queue and stage are full
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++) cyc(1, dval(i), 0, 0, 0);
    cyc(1, 8'h77, 0, 1, 0);
    chk("R4 no ovr", st_ovr, 0);
    chk("R4 still full", st_full, 1);
    for (int k = 1; k <= DEPTH; k++) begin
      chk("R4 order", rd_data, dval(k));
      cyc(0, 0, 0, 1, 0);
    end
    chk("R4 new char", rd_data, 8'h77);

    // R5: overrun and clear in same cycle -> overrun wins
    do_reset();
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, dval(i), 0, 0, 1);
    chk("R5 set wins", st_ovr, 1);

    // R7: accumulate mode over all flag triples
    blk_mode = 1;
    for (int f = 0; f < 512; f++) begin
      logic [2:0] f0, f1, f2;
      f0 = 3'(f); f1 = 3'(f >> 3); f2 = 3'(f >> 6);
      do_reset();
      cyc(1, 8'h01, f0, 0, 0);
      cyc(1, 8'h02, f1, 0, 0);
      cyc(1, 8'h03, f2, 0, 0);
      chk("R7 first head", flg(), f0);
      cyc(0, 0, 0, 1, 0);
      chk("R7 second head", flg(), f0 | f1);
      cyc(0, 0, 0, 1, 0);
      chk("R7 third head", flg(), f0 | f1 | f2);
    end

    // R8: clear keeps queue; clear with a simultaneous new head
    do_reset();
    cyc(1, 8'h11, 3'b100, 0, 0);
    cyc(1, 8'h22, 3'b010, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R8 acc cleared", flg(), 0);
    chk("R8 data kept", rd_data, 8'h11);
    cyc(0, 0, 0, 1, 1);
    chk("R8 head after clear", flg(), 3'b010);
    blk_mode = 0; #1;
    chk("R6 char mode back", flg(), 3'b010);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule